// File: doc/BRIEF.md
# Priority-Threshold Receive Admission Controller

This block sits in front of a shared receive buffer and decides, for every packet that starts to arrive, whether it may take space in the buffer or must be answered with a retry. The buffer is counted in 64-byte blocks. The controller keeps a running count of free blocks. It takes blocks away when it admits a packet and gives them back when the consumer of the buffer reports that it has released them.

Admission is graded by the 2-bit packet priority. Three programmable free-space levels are stacked so that lower priorities are turned away first as the buffer fills. This leaves room for higher-priority traffic, which is what keeps the link free of deadlock. The top priority is refused only when the buffer is full. Threshold sets are checked before use, and an illegal set is refused while the previous set stays in force.

Top module: `rx_admit_ctrl`

## Requirements
- R1: A request with `req_valid` high is answered on the next clock edge: `rsp_valid` is high for exactly that one cycle, with `rsp_accept` = 1 for accept and 0 for retry. A cycle with no request gives `rsp_valid` = 0 and `rsp_accept` = 0.
- R2: Priority value 0 (the lowest) is retried when the free block count is below the priority-0 threshold.
- R3: Priority value 1 is retried when the free block count is below the priority-1 threshold, and for no other threshold reason.
- R4: Priority value 2 is retried when the free block count is below the priority-2 threshold, and for no other threshold reason.
- R5: Priority value 3 (the highest) ignores all thresholds and is retried when the free count is zero.
- R6: A packet needs ceil(`req_len` / 64) blocks, with a minimum of one block, so a length of 0 counts as one block. Any packet, at any priority, is retried when it needs more blocks than are free. The decision uses the free count held before the edge on which it is taken.
- R7: An accepted packet reduces `free_count` by the blocks it needs, on the same edge that raises `rsp_accept`.
- R8: A release adds `rel_count` blocks to `free_count`. When an allocation and a release fall on the same edge, the two are applied together.
- R9: If a release would push the free count above the buffer size, `free_count` saturates at the buffer size and `rel_err` is set. `rel_err` stays set until reset.
- R10: After reset, `free_count` equals the buffer size, `rsp_valid`, `rsp_accept`, `cfg_err` and `rel_err` are 0, and the thresholds are 20 for priority 0, 15 for priority 1 and 10 for priority 2.
- R11: A threshold set is legal when all four hold: the priority-2 threshold is at least 10, the priority-1 threshold is at least the priority-2 threshold plus 5, the priority-0 threshold is at least the priority-1 threshold plus 5, and the priority-0 threshold is below the buffer size. A load of an illegal set sets `cfg_err` and keeps the old thresholds. A load of a legal set clears `cfg_err`.
- R12: A legal threshold set takes effect for requests presented on the clock edge after the load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet start request |
| req_prio | input | 2 | Packet priority, 0 lowest, 3 highest |
| req_len | input | LEN_W | Packet length in bytes |
| rel_valid | input | 1 | Block release strobe |
| rel_count | input | CNT_W | Number of blocks released |
| cfg_load | input | 1 | Load a new threshold set |
| cfg_thr0 | input | CNT_W | New priority-0 threshold |
| cfg_thr1 | input | CNT_W | New priority-1 threshold |
| cfg_thr2 | input | CNT_W | New priority-2 threshold |
| rsp_valid | output | 1 | Decision valid, one cycle after the request |
| rsp_accept | output | 1 | 1 accept, 0 retry |
| free_count | output | CNT_W | Free blocks in the buffer |
| cfg_err | output | 1 | Last threshold load was refused |
| rel_err | output | 1 | A release overflowed the count; held until reset |

## Verification
The bench builds the block with a buffer of 26 blocks in place of the default 32, and keeps the default length width and thresholds. At this size a few five-block packets bring the free count down through every threshold and then to zero, so each priority's boundary and the full-buffer case are reached within a few dozen cycles. The priority-0 limit of "below the buffer size" can also be probed at 26, since that value still fits in the count width. A randomized phase then mixes requests, releases and threshold loads against the behavioural model.

// File: rtl/rx_admit_pkg.sv
package rx_admit_pkg;

  typedef enum logic [1:0] {
    PRIO_LOW  = 2'd0,
    PRIO_MID  = 2'd1,
    PRIO_HIGH = 2'd2,
    PRIO_TOP  = 2'd3
  } prio_e;

  // Blocks occupied by a packet of len_bytes; an empty packet still holds one.
  function automatic int blocks_for_len(int len_bytes, int block_bytes);
    int n;
    n = (len_bytes + block_bytes - 1) / block_bytes;
    if (n < 1) n = 1;
    return n;
  endfunction

  // Stacked levels must be spaced by one maximum packet.
  function automatic bit thr_set_legal(int t0, int t1, int t2, int total, int max_pkt);
    return (t2 > 2 * max_pkt - 1) &&
           (t1 > t2 + max_pkt - 1) &&
           (t0 > t1 + max_pkt - 1) &&
           (t0 < total);
  endfunction

endpackage

// File: rtl/admit_thr_regs.sv
module admit_thr_regs import rx_admit_pkg::*; #(
  parameter int CNT_W          = 6,
  parameter int TOTAL_BLOCKS   = 32,
  parameter int MAX_PKT_BLOCKS = 5,
  parameter int DEF_THR0       = 20,
  parameter int DEF_THR1       = 15,
  parameter int DEF_THR2       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_thr0,
  input  logic [CNT_W-1:0] cfg_thr1,
  input  logic [CNT_W-1:0] cfg_thr2,
  output logic [CNT_W-1:0] thr0,
  output logic [CNT_W-1:0] thr1,
  output logic [CNT_W-1:0] thr2,
  output logic             cfg_legal,
  output logic             cfg_err
);

  assign cfg_legal = thr_set_legal(int'(cfg_thr0), int'(cfg_thr1), int'(cfg_thr2),
                                   TOTAL_BLOCKS, MAX_PKT_BLOCKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr0    <= CNT_W'(DEF_THR0);
      thr1    <= CNT_W'(DEF_THR1);
      thr2    <= CNT_W'(DEF_THR2);
      cfg_err <= 1'b0;
    end else if (cfg_load) begin
      if (cfg_legal) begin
        thr0    <= cfg_thr0;
        thr1    <= cfg_thr1;
        thr2    <= cfg_thr2;
        cfg_err <= 1'b0;
      end else begin
        cfg_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/admit_decide.sv
module admit_decide import rx_admit_pkg::*; #(
  parameter int CNT_W  = 6,
  parameter int NEED_W = 4
) (
  input  logic [1:0]        prio,
  input  logic [NEED_W-1:0] need,
  input  logic [CNT_W-1:0]  free_blk,
  input  logic [CNT_W-1:0]  thr0,
  input  logic [CNT_W-1:0]  thr1,
  input  logic [CNT_W-1:0]  thr2,
  output logic              admit
);

  logic [2:0][CNT_W-1:0] thr_arr;
  logic [2:0]            below;
  logic                  fits;

  assign thr_arr = {thr2, thr1, thr0};

  for (genvar p = 0; p < 3; p++) begin : g_cmp
    assign below[p] = free_blk < thr_arr[p];
  end

  assign fits = int'(need) <= int'(free_blk);

  always_comb begin
    unique case (prio_e'(prio))
      PRIO_LOW:  admit = fits & ~below[0];
      PRIO_MID:  admit = fits & ~below[1];
      PRIO_HIGH: admit = fits & ~below[2];
      default:   admit = fits & (free_blk != '0);
    endcase
  end

endmodule

// File: rtl/admit_free_ctr.sv
module admit_free_ctr #(
  parameter int TOTAL_BLOCKS = 32,
  parameter int CNT_W        = 6,
  parameter int NEED_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [NEED_W-1:0] need,
  input  logic              rel_valid,
  input  logic [CNT_W-1:0]  rel_count,
  output logic [CNT_W-1:0]  free_count,
  output logic              rel_over,
  output logic              rel_err
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(TOTAL_BLOCKS);

  int               next_sum;
  logic [CNT_W-1:0] free_d;

  always_comb begin
    next_sum = int'(free_count);
    if (alloc)     next_sum = next_sum - int'(need);
    if (rel_valid) next_sum = next_sum + int'(rel_count);
    rel_over = next_sum > TOTAL_BLOCKS;
    free_d   = rel_over ? FULL : CNT_W'(next_sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_count <= FULL;
      rel_err    <= 1'b0;
    end else begin
      free_count <= free_d;
      if (rel_over) rel_err <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_admit_ctrl.sv
module rx_admit_ctrl import rx_admit_pkg::*; #(
  parameter  int TOTAL_BLOCKS   = 32,
  parameter  int BLOCK_BYTES    = 64,
  parameter  int LEN_W          = 9,
  parameter  int MAX_PKT_BLOCKS = 5,
  parameter  int DEF_THR0       = 20,
  parameter  int DEF_THR1       = 15,
  parameter  int DEF_THR2       = 10,
  localparam int CNT_W          = $clog2(TOTAL_BLOCKS + 1),
  localparam int NEED_W         = LEN_W - $clog2(BLOCK_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_prio,
  input  logic [LEN_W-1:0] req_len,
  input  logic             rel_valid,
  input  logic [CNT_W-1:0] rel_count,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_thr0,
  input  logic [CNT_W-1:0] cfg_thr1,
  input  logic [CNT_W-1:0] cfg_thr2,
  output logic             rsp_valid,
  output logic             rsp_accept,
  output logic [CNT_W-1:0] free_count,
  output logic             cfg_err,
  output logic             rel_err
);

  // Named internal events
  logic [NEED_W-1:0] need_w;
  logic              admit_w;
  logic              alloc_fire;
  logic              rel_over_w;
  logic              cfg_legal_w;
  logic [CNT_W-1:0]  thr0, thr1, thr2;

  assign need_w     = NEED_W'(blocks_for_len(int'(req_len), BLOCK_BYTES));
  assign alloc_fire = req_valid & admit_w;

  admit_thr_regs #(
    .CNT_W(CNT_W), .TOTAL_BLOCKS(TOTAL_BLOCKS), .MAX_PKT_BLOCKS(MAX_PKT_BLOCKS),
    .DEF_THR0(DEF_THR0), .DEF_THR1(DEF_THR1), .DEF_THR2(DEF_THR2)
  ) u_thr (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_thr0(cfg_thr0), .cfg_thr1(cfg_thr1), .cfg_thr2(cfg_thr2),
    .thr0(thr0), .thr1(thr1), .thr2(thr2),
    .cfg_legal(cfg_legal_w), .cfg_err(cfg_err)
  );

  admit_decide #(.CNT_W(CNT_W), .NEED_W(NEED_W)) u_dec (
    .prio(req_prio), .need(need_w), .free_blk(free_count),
    .thr0(thr0), .thr1(thr1), .thr2(thr2), .admit(admit_w)
  );

  admit_free_ctr #(.TOTAL_BLOCKS(TOTAL_BLOCKS), .CNT_W(CNT_W), .NEED_W(NEED_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .alloc(alloc_fire), .need(need_w),
    .rel_valid(rel_valid), .rel_count(rel_count),
    .free_count(free_count), .rel_over(rel_over_w), .rel_err(rel_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_accept <= alloc_fire;
    end
  end

endmodule

// File: rtl/rx_admit_chk.sv
module rx_admit_chk #(
  parameter int TOTAL_BLOCKS = 32,
  parameter int CNT_W        = 6,
  parameter int NEED_W       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_prio,
  input logic              rel_valid,
  input logic              cfg_load,
  input logic              rsp_valid,
  input logic              rsp_accept,
  input logic [CNT_W-1:0]  free_count,
  input logic              rel_err,
  input logic [NEED_W-1:0] need_w,
  input logic              cfg_legal_w,
  input logic [CNT_W-1:0]  thr0,
  input logic [CNT_W-1:0]  thr1,
  input logic [CNT_W-1:0]  thr2
);

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_accept));

  assert_low_prio_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_accept && $past(req_prio) == 2'd0) |-> ($past(free_count) >= $past(thr0)));

  assert_top_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_accept && $past(req_prio) == 2'd3)
      |-> (int'($past(need_w)) > int'($past(free_count))));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept |-> (int'($past(need_w)) <= int'($past(free_count))));

  assert_alloc_debit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_accept && !$past(rel_valid))
      |-> (int'(free_count) == int'($past(free_count)) - int'($past(need_w))));

  assert_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_count) <= TOTAL_BLOCKS);

  assert_rel_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |=> rel_err);

  assert_cfg_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !cfg_legal_w) |=> ($stable(thr0) && $stable(thr1) && $stable(thr2)));

endmodule

bind rx_admit_ctrl rx_admit_chk #(
  .TOTAL_BLOCKS(TOTAL_BLOCKS), .CNT_W(CNT_W), .NEED_W(NEED_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
  .rel_valid(rel_valid), .cfg_load(cfg_load), .rsp_valid(rsp_valid),
  .rsp_accept(rsp_accept), .free_count(free_count), .rel_err(rel_err),
  .need_w(need_w), .cfg_legal_w(cfg_legal_w),
  .thr0(thr0), .thr1(thr1), .thr2(thr2)
);

// File: tb/rx_admit_ctrl_tb.sv
`timescale 1ns/1ps
module rx_admit_ctrl_tb;

  localparam int TOT   = 26;
  localparam int LEN_W = 9;
  localparam int CNT_W = $clog2(TOT + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [1:0]       req_prio = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             rel_valid = 1'b0;
  logic [CNT_W-1:0] rel_count = '0;
  logic             cfg_load = 1'b0;
  logic [CNT_W-1:0] cfg_thr0 = '0, cfg_thr1 = '0, cfg_thr2 = '0;
  logic             rsp_valid, rsp_accept, cfg_err, rel_err;
  logic [CNT_W-1:0] free_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int m_free, m_t0, m_t1, m_t2;
  bit m_cerr, m_rerr, m_rv, m_ra;

  always #4 clk = ~clk;

  rx_admit_ctrl #(.TOTAL_BLOCKS(TOT), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
    .req_len(req_len), .rel_valid(rel_valid), .rel_count(rel_count),
    .cfg_load(cfg_load), .cfg_thr0(cfg_thr0), .cfg_thr1(cfg_thr1), .cfg_thr2(cfg_thr2),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .free_count(free_count),
    .cfg_err(cfg_err), .rel_err(rel_err)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int blocks_of(int len);
    int n = 0;
    int left = len;
    while (left > 0) begin
      n++;
      left -= 64;
    end
    return (n == 0) ? 1 : n;
  endfunction

  function automatic bit admit_of(int prio, int len);
    int need = blocks_of(len);
    if (need > m_free) return 0;
    if (prio == 3) return m_free != 0;
    if (prio == 2) return m_free >= m_t2;
    if (prio == 1) return m_free >= m_t1;
    return m_free >= m_t0;
  endfunction

  function automatic bit legal_of(int a0, int a1, int a2);
    return (a2 >= 10) && (a1 - a2 >= 5) && (a0 - a1 >= 5) && (a0 <= TOT - 1);
  endfunction

  // one clock: drive, update model, compare after the edge
  task automatic step(string tag, bit rv, int prio, int len, bit lv, int lc,
                      bit ld, int a0, int a1, int a2);
    bit acc;
    int nf;
    req_valid = rv; req_prio = 2'(prio); req_len = LEN_W'(len);
    rel_valid = lv; rel_count = CNT_W'(lc);
    cfg_load = ld; cfg_thr0 = CNT_W'(a0); cfg_thr1 = CNT_W'(a1); cfg_thr2 = CNT_W'(a2);
    acc = rv && admit_of(prio, len);
    nf  = m_free - (acc ? blocks_of(len) : 0) + (lv ? lc : 0);
    if (nf > TOT) begin
      nf = TOT;
      m_rerr = 1;
    end
    if (ld) begin
      if (legal_of(a0, a1, a2)) begin
        m_t0 = a0; m_t1 = a1; m_t2 = a2; m_cerr = 0;
      end else m_cerr = 1;
    end
    m_free = nf; m_rv = rv; m_ra = acc;
    @(posedge clk);
    #2;
    chk(tag, "rsp_valid", int'(rsp_valid), int'(m_rv));
    chk(tag, "rsp_accept", int'(rsp_accept), int'(m_ra));
    chk(tag, "free_count", int'(free_count), m_free);
    chk(tag, "cfg_err", int'(cfg_err), int'(m_cerr));
    chk(tag, "rel_err", int'(rel_err), int'(m_rerr));
    @(negedge clk);
  endtask

  task automatic req(string tag, int prio, int len);
    step(tag, 1, prio, len, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rel(string tag, int cnt);
    step(tag, 0, 0, 0, 1, cnt, 0, 0, 0, 0);
  endtask

  task automatic cfg(string tag, int a0, int a1, int a2);
    step(tag, 0, 0, 0, 0, 0, 1, a0, a1, a2);
  endtask

  task automatic do_reset();
    rst_n = 0;
    req_valid = 0; rel_valid = 0; cfg_load = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_free = TOT; m_t0 = 20; m_t1 = 15; m_t2 = 10;
    m_cerr = 0; m_rerr = 0; m_rv = 0; m_ra = 0;
  endtask

  initial begin
    do_reset();
    // R10 reset state
    chk("R10", "free_count", int'(free_count), TOT);
    chk("R10", "rsp_valid", int'(rsp_valid), 0);
    chk("R10", "rsp_accept", int'(rsp_accept), 0);
    chk("R10", "cfg_err", int'(cfg_err), 0);
    chk("R10", "rel_err", int'(rel_err), 0);

    // R6 block rounding
    req("R6", 3, 64);  rel("R6", 1);
    req("R6", 3, 65);  chk("R6", "two blocks", int'(free_count), TOT - 2); rel("R6", 2);
    req("R6", 3, 0);   chk("R6", "zero len one block", int'(free_count), TOT - 1); rel("R6", 1);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2 priority 0 against default level 20 (R10)
    req("R2", 0, 320);  // 26 -> 21
    req("R2", 0, 320);  // 21 -> 16
    req("R2", 0, 64);   // 16 < 20 retry
    chk("R2", "retry at 16", int'(rsp_accept), 0);
    // R3 priority 1 against 15
    req("R3", 1, 320);  // 16 -> 11
    req("R3", 1, 64);   // 11 < 15 retry
    chk("R3", "retry at 11", int'(rsp_accept), 0);
    // R4 priority 2 against 10
    req("R4", 2, 64);   // 11 -> 10
    req("R4", 2, 64);   // 10 -> 9 (equal accepted)
    chk("R4", "accept at level", int'(rsp_accept), 1);
    req("R4", 2, 64);   // 9 retry
    chk("R4", "retry at 9", int'(rsp_accept), 0);
    // R5 / R6 top priority
    req("R5", 3, 320);  // 9 -> 4
    req("R6", 3, 320);  // need 5 > 4 retry
    chk("R6", "oversize retry", int'(rsp_accept), 0);
    req("R5", 3, 256);  // 4 -> 0
    req("R5", 3, 1);    // full retry
    chk("R5", "full retry", int'(rsp_accept), 0);
    // R8 simultaneous
    step("R8", 1, 3, 1, 1, 3, 0, 0, 0, 0);   // decision on 0 -> retry, free 3
    chk("R8", "old count decides", int'(rsp_accept), 0);
    step("R8", 1, 3, 64, 1, 2, 0, 0, 0, 0);  // 3 - 1 + 2 = 4
    chk("R8", "both applied", int'(free_count), 4);
    // R7 plain debit
    req("R7", 3, 130);  // 4 -> 1
    // R9 over-release
    rel("R9", 30);
    chk("R9", "saturate", int'(free_count), TOT);
    chk("R9", "rel_err set", int'(rel_err), 1);
    rel("R9", 0);

    // R11 illegal sets keep thresholds
    cfg("R11", 19, 14, 9);
    chk("R11", "cfg_err", int'(cfg_err), 1);
    cfg("R11", 24, 19, 15);   // priority-1 gap of 4
    req("R3", 3, 320);  // 26 -> 21
    req("R3", 3, 64);   // 20
    req("R3", 3, 64);   // 19
    req("R11", 0, 64);  // 19 < 20 retry: old level kept
    rel("R11", 7);      // 26
    // R11 / R12 legal load then immediate use
    cfg("R11", 22, 17, 12);
    chk("R11", "cfg_err cleared", int'(cfg_err), 0);
    req("R12", 3, 320);  // 21
    req("R12", 0, 64);   // 21 < 22 retry
    chk("R12", "new level used", int'(rsp_accept), 0);
    cfg("R11", 26, 17, 12);  // priority-0 not below size
    chk("R11", "limit refused", int'(cfg_err), 1);
    rel("R12", 1);       // 22
    req("R12", 0, 64);   // 22 >= 22 accept
    chk("R12", "accept at new level", int'(rsp_accept), 1);

    // randomized mix against the model
    do_reset();
    for (int i = 0; i < 800; i++) begin
      bit rv = 1'($urandom % 2);
      bit lv = ($urandom % 3) == 0;
      int lc = int'($urandom % 6);
      bit ld = ($urandom % 23) == 0;
      if (lc > TOT - m_free) lc = TOT - m_free;
      step("R7", rv, int'($urandom % 4), int'($urandom % 321), lv, lc,
           ld, 15 + int'($urandom % 12), 8 + int'($urandom % 12), 6 + int'($urandom % 8));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule